// File: doc/BRIEF.md
# Tree Multicast Spike Router Node

This block is one node of a tree of chips that exchange spike packets. Each node has a single link toward its parent, a parameterised set of child links (two by default, so each node talks to three neighbours) and a port to its own neuron array. The router holds no routing table. Every packet carries its whole path in its header: a count of hops still to climb, a flood flag, a count of remaining downward hops and a list of 2-bit child selectors.

A packet with a nonzero climb count goes to the parent with the count reduced by one. Once the count is zero, the packet descends. Each node takes the lowest selector, shifts the list down and reduces the downward count. When no selectors remain, the packet goes to the local array. A flagged packet is copied unchanged to every child and to the local port, so the whole subtree below the turning node receives it. Flooding on the way up is forbidden, and such packets are discarded with an error pulse, so the tree routes never form a cycle.

Inputs compete through a round-robin arbiter. One packet at a time is held in a single stage register. It is released when every destination has taken its copy through valid/ready handshakes.

Top module: `tree_router`

Header layout, LSB first: payload `[PAY_W-1:0]`, then `MAX_DN` 2-bit selectors (hop 0 in the lowest pair), then the down count (`$clog2(MAX_DN+1)` bits), then the up count (`UP_W` bits), then the flood flag in the MSB. With the defaults the packet is 31 bits: payload [15:0], selectors [23:16], down count [26:24], up count [29:27] and flood [30].

## Requirements
- R1: After reset, and before any input is offered, every output valid and `err_o` are low.
- R2: A packet with up count nonzero and flood clear appears on the parent output with the up count reduced by one and every other bit unchanged.
- R3: A packet with up count zero, flood clear and down count nonzero goes to the child whose index equals selector bits [1:0] of the list. The list is shifted right by two with zero fill, the down count is reduced by one, and the other bits are unchanged.
- R4: A packet with up count, down count and flood all zero is delivered unchanged to the local output only.
- R5: A packet with up count zero and flood set is copied unchanged to every child output and to the local output, and never to the parent.
- R6: A packet with flood set and up count nonzero produces no output. `err_o` is high for exactly the one cycle after its acceptance.
- R7: A descending, non-flooded packet whose selector is not below `NUM_CHILD` produces no output and pulses `err_o` for one cycle.
- R8: Each output keeps valid high and data stable until it sees its own ready. A copy that has been taken is not offered again. The stage is freed only after all destinations have accepted.
- R9: At most one input is ready in any cycle, no input is ready while a packet is held, and inputs that stay valid are each served in rotation.
- R10: A packet accepted at a clock edge is presented on its outputs from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_in_valid_i | input | 1 | Packet from parent valid |
| par_in_data_i | input | PKT_W | Packet from parent |
| par_in_ready_o | output | 1 | Parent input accepted |
| loc_in_valid_i | input | 1 | Packet from local array valid |
| loc_in_data_i | input | PKT_W | Packet from local array |
| loc_in_ready_o | output | 1 | Local input accepted |
| chd_in_valid_i | input | NUM_CHILD | Per-child input valid |
| chd_in_data_i | input | NUM_CHILD*PKT_W | Per-child input packets, child c at [c*PKT_W +: PKT_W] |
| chd_in_ready_o | output | NUM_CHILD | Per-child input accepted |
| par_out_valid_o | output | 1 | Packet to parent valid |
| par_out_data_o | output | PKT_W | Packet to parent |
| par_out_ready_i | input | 1 | Parent takes packet |
| loc_out_valid_o | output | 1 | Packet to local array valid |
| loc_out_data_o | output | PKT_W | Packet to local array |
| loc_out_ready_i | input | 1 | Local array takes packet |
| chd_out_valid_o | output | NUM_CHILD | Per-child output valid |
| chd_out_data_o | output | NUM_CHILD*PKT_W | Per-child output packets |
| chd_out_ready_i | input | NUM_CHILD | Per-child take |
| err_o | output | 1 | One-cycle pulse on a discarded packet |

## Verification
The hold checks assume that a valid input keeps its data until its ready is seen, and that an output's ready is a plain function of the sink's state. The stimulus raises valid at a falling edge and holds it until the handshake edge. Ready levels change only at falling edges. Random packets mix climb counts, flooding, empty and full selector lists, and out-of-range selectors. All of them arrive on randomly chosen inputs, and the expected output mask and header come from bench functions. Directed cases cover partial acceptance of flooded copies under backpressure, and four inputs contending at the same time.

// File: rtl/tree_router_pkg.sv
package tree_router_pkg;
  localparam int SEL_W    = 2;
  // output/input port index map
  localparam int PORT_PAR = 0;
  localparam int PORT_LOC = 1;
  localparam int PORT_CHD = 2;

  function automatic int pkt_width(int up_w, int max_dn, int pay_w);
    return 1 + up_w + $clog2(max_dn + 1) + SEL_W * max_dn + pay_w;
  endfunction
endpackage

// File: rtl/hop_decode.sv
module hop_decode
  import tree_router_pkg::*;
#(
  parameter int NUM_CHILD = 2,
  parameter int UP_W      = 3,
  parameter int MAX_DN    = 4,
  parameter int PAY_W     = 16,
  localparam int PKT_W    = pkt_width(UP_W, MAX_DN, PAY_W),
  localparam int NPORT    = NUM_CHILD + 2
) (
  input  logic [PKT_W-1:0] pkt_i,
  output logic [PKT_W-1:0] pkt_o,
  output logic [NPORT-1:0] dest_o,
  output logic             drop_o
);
  localparam int DN_W    = $clog2(MAX_DN + 1);
  localparam int LST_W   = SEL_W * MAX_DN;
  localparam int LST_LSB = PAY_W;
  localparam int DNC_LSB = LST_LSB + LST_W;
  localparam int UPC_LSB = DNC_LSB + DN_W;
  localparam int FLD_BIT = UPC_LSB + UP_W;

  logic             flood;
  logic [UP_W-1:0]  up_cnt;
  logic [DN_W-1:0]  dn_cnt;
  logic [LST_W-1:0] lst;
  logic [SEL_W-1:0] sel;

  assign flood  = pkt_i[FLD_BIT];
  assign up_cnt = pkt_i[UPC_LSB +: UP_W];
  assign dn_cnt = pkt_i[DNC_LSB +: DN_W];
  assign lst    = pkt_i[LST_LSB +: LST_W];
  assign sel    = lst[SEL_W-1:0];

  always_comb begin
    pkt_o  = pkt_i;
    dest_o = '0;
    drop_o = 1'b0;
    if (up_cnt != '0) begin
      if (flood) drop_o = 1'b1;
      else begin
        pkt_o[UPC_LSB +: UP_W] = up_cnt - 1'b1;
        dest_o[PORT_PAR]       = 1'b1;
      end
    end else if (flood) begin
      dest_o[PORT_LOC] = 1'b1;
      for (int c = 0; c < NUM_CHILD; c++) dest_o[PORT_CHD + c] = 1'b1;
    end else if (dn_cnt == '0) begin
      dest_o[PORT_LOC] = 1'b1;
    end else begin
      drop_o = 1'b1;
      for (int c = 0; c < NUM_CHILD; c++) begin
        if (sel == SEL_W'(c)) begin
          dest_o[PORT_CHD + c] = 1'b1;
          drop_o               = 1'b0;
        end
      end
      pkt_o[LST_LSB +: LST_W] = lst >> SEL_W;
      pkt_o[DNC_LSB +: DN_W]  = dn_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rr_arb.sv
module rr_arb #(
  parameter int N    = 4,
  localparam int PW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  logic [PW-1:0] ptr_q;
  int            j;
  int            nxt;
  logic          found;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    nxt   = int'(ptr_q);
    j     = 0;
    for (int k = 0; k < N; k++) begin
      j = int'(ptr_q) + k;
      if (j >= N) j = j - N;
      if (!found && req_i[j]) begin
        gnt_o[j] = 1'b1;
        found    = 1'b1;
        nxt      = (j + 1 >= N) ? 0 : j + 1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= PW'(nxt);
  end

  a_r9_gnt_in_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/tree_router.sv
module tree_router
  import tree_router_pkg::*;
#(
  parameter int NUM_CHILD = 2,
  parameter int UP_W      = 3,
  parameter int MAX_DN    = 4,
  parameter int PAY_W     = 16,
  localparam int PKT_W    = pkt_width(UP_W, MAX_DN, PAY_W)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       par_in_valid_i,
  input  logic [PKT_W-1:0]           par_in_data_i,
  output logic                       par_in_ready_o,
  input  logic                       loc_in_valid_i,
  input  logic [PKT_W-1:0]           loc_in_data_i,
  output logic                       loc_in_ready_o,
  input  logic [NUM_CHILD-1:0]       chd_in_valid_i,
  input  logic [NUM_CHILD*PKT_W-1:0] chd_in_data_i,
  output logic [NUM_CHILD-1:0]       chd_in_ready_o,
  output logic                       par_out_valid_o,
  output logic [PKT_W-1:0]           par_out_data_o,
  input  logic                       par_out_ready_i,
  output logic                       loc_out_valid_o,
  output logic [PKT_W-1:0]           loc_out_data_o,
  input  logic                       loc_out_ready_i,
  output logic [NUM_CHILD-1:0]       chd_out_valid_o,
  output logic [NUM_CHILD*PKT_W-1:0] chd_out_data_o,
  input  logic [NUM_CHILD-1:0]       chd_out_ready_i,
  output logic                       err_o
);
  localparam int NPORT   = NUM_CHILD + 2;
  localparam int DN_W    = $clog2(MAX_DN + 1);
  localparam int DNC_LSB = PAY_W + SEL_W * MAX_DN;
  localparam int UPC_LSB = DNC_LSB + DN_W;
  localparam int FLD_BIT = UPC_LSB + UP_W;

  logic [NPORT-1:0] in_vld, in_rdy, gnt;
  logic [PKT_W-1:0] in_dat [NPORT];
  logic [PKT_W-1:0] sel_pkt, dec_pkt;
  logic [NPORT-1:0] dec_dest;
  logic             dec_drop, accept;

  logic             busy_q, err_q;
  logic [NPORT-1:0] pend_q;
  logic [PKT_W-1:0] pkt_q;
  logic [NPORT-1:0] out_vld, out_rdy, fire, rem;

  // port gathering
  assign in_vld[PORT_PAR] = par_in_valid_i;
  assign in_dat[PORT_PAR] = par_in_data_i;
  assign in_vld[PORT_LOC] = loc_in_valid_i;
  assign in_dat[PORT_LOC] = loc_in_data_i;
  assign par_in_ready_o   = in_rdy[PORT_PAR];
  assign loc_in_ready_o   = in_rdy[PORT_LOC];

  assign out_rdy[PORT_PAR] = par_out_ready_i;
  assign out_rdy[PORT_LOC] = loc_out_ready_i;
  assign par_out_valid_o   = out_vld[PORT_PAR];
  assign loc_out_valid_o   = out_vld[PORT_LOC];
  assign par_out_data_o    = pkt_q;
  assign loc_out_data_o    = pkt_q;

  for (genvar c = 0; c < NUM_CHILD; c++) begin : g_chd
    assign in_vld[PORT_CHD+c]               = chd_in_valid_i[c];
    assign in_dat[PORT_CHD+c]               = chd_in_data_i[c*PKT_W +: PKT_W];
    assign chd_in_ready_o[c]                = in_rdy[PORT_CHD+c];
    assign chd_out_valid_o[c]               = out_vld[PORT_CHD+c];
    assign chd_out_data_o[c*PKT_W +: PKT_W] = pkt_q;
    assign out_rdy[PORT_CHD+c]              = chd_out_ready_i[c];
  end

  rr_arb #(.N(NPORT)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (in_vld),
    .adv_i (accept),
    .gnt_o (gnt)
  );

  always_comb begin
    sel_pkt = '0;
    for (int i = 0; i < NPORT; i++) if (gnt[i]) sel_pkt = sel_pkt | in_dat[i];
  end

  assign in_rdy = busy_q ? '0 : gnt;
  assign accept = |in_rdy;

  hop_decode #(
    .NUM_CHILD(NUM_CHILD), .UP_W(UP_W), .MAX_DN(MAX_DN), .PAY_W(PAY_W)
  ) u_dec (
    .pkt_i (sel_pkt),
    .pkt_o (dec_pkt),
    .dest_o(dec_dest),
    .drop_o(dec_drop)
  );

  // single holding stage; freed when every destination has its copy
  assign out_vld = pend_q;
  assign fire    = pend_q & out_rdy;
  assign rem     = pend_q & ~fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= '0;
      pkt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept & dec_drop;
      if (busy_q) begin
        pend_q <= rem;
        busy_q <= |rem;
      end else if (accept && !dec_drop) begin
        busy_q <= 1'b1;
        pend_q <= dec_dest;
        pkt_q  <= dec_pkt;
      end
    end
  end

  assign err_o = err_q;

  // R5: nothing flooded ever climbs
  a_r5_no_flood_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_out_valid_o |-> !par_out_data_o[FLD_BIT]);

  // R4: unflooded local delivery has consumed its whole route
  a_r4_local_route_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_out_valid_o && !loc_out_data_o[FLD_BIT]) |->
      (loc_out_data_o[DNC_LSB +: DN_W] == '0 && loc_out_data_o[UPC_LSB +: UP_W] == '0));

  // R6/R7: a discard produces no output
  a_r6_err_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (out_vld == '0));

  // R9: one input ready at most, none while held
  a_r9_single_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_rdy) && (busy_q -> in_rdy == '0));

  // R8: each output holds until taken
  for (genvar p = 0; p < NPORT; p++) begin : g_hold
    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld[p] && !out_rdy[p]) |=> (out_vld[p] && $stable(pkt_q)));
    a_r8_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld[p] && out_rdy[p]) |=> !out_vld[p]);
  end
endmodule

// File: tb/tree_router_tb.sv
module tree_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC    = 2;
  localparam int UP_W  = 3;
  localparam int MAXD  = 4;
  localparam int PAY_W = 16;
  localparam int DN_W  = 3;
  localparam int PKT_W = 1 + UP_W + DN_W + 2*MAXD + PAY_W;
  localparam int LST_L = PAY_W;
  localparam int DNC_L = LST_L + 2*MAXD;
  localparam int UPC_L = DNC_L + DN_W;
  localparam int FLD_B = UPC_L + UP_W;
  localparam int NP    = NC + 2;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             par_in_v = 0, loc_in_v = 0;
  logic [PKT_W-1:0] par_in_d = '0, loc_in_d = '0;
  logic             par_in_r, loc_in_r;
  logic [NC-1:0]    chd_in_v = '0;
  logic [NC*PKT_W-1:0] chd_in_d = '0;
  logic [NC-1:0]    chd_in_r;
  logic             par_out_v, loc_out_v;
  logic [PKT_W-1:0] par_out_d, loc_out_d;
  logic             par_out_r = 1, loc_out_r = 1;
  logic [NC-1:0]    chd_out_v;
  logic [NC*PKT_W-1:0] chd_out_d;
  logic [NC-1:0]    chd_out_r = '1;
  logic             err;

  tree_router u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .par_in_valid_i(par_in_v), .par_in_data_i(par_in_d), .par_in_ready_o(par_in_r),
    .loc_in_valid_i(loc_in_v), .loc_in_data_i(loc_in_d), .loc_in_ready_o(loc_in_r),
    .chd_in_valid_i(chd_in_v), .chd_in_data_i(chd_in_d), .chd_in_ready_o(chd_in_r),
    .par_out_valid_o(par_out_v), .par_out_data_o(par_out_d), .par_out_ready_i(par_out_r),
    .loc_out_valid_o(loc_out_v), .loc_out_data_o(loc_out_d), .loc_out_ready_i(loc_out_r),
    .chd_out_valid_o(chd_out_v), .chd_out_data_o(chd_out_d), .chd_out_ready_i(chd_out_r),
    .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [PKT_W-1:0] mk(bit fl, int up, int dn, logic [7:0] sel, logic [15:0] pay);
    logic [PKT_W-1:0] p;
    p = '0;
    p[FLD_B] = fl;
    p[UPC_L +: UP_W] = UP_W'(up);
    p[DNC_L +: DN_W] = DN_W'(dn);
    p[LST_L +: 8] = sel;
    p[PAY_W-1:0] = pay;
    return p;
  endfunction

  // expected routing per the requirements; mask bit 0 parent, 1 local, 2+c child c
  logic [NP-1:0]    e_mask;
  logic [PKT_W-1:0] e_pkt;
  bit               e_drop;
  string            e_req;

  task automatic expect_of(logic [PKT_W-1:0] p);
    logic [UP_W-1:0] up;
    logic [DN_W-1:0] dn;
    logic [1:0] s;
    up = p[UPC_L +: UP_W];
    dn = p[DNC_L +: DN_W];
    s  = p[LST_L +: 2];
    e_pkt = p; e_mask = '0; e_drop = 0;
    if (up != 0 && p[FLD_B]) begin e_drop = 1; e_req = "R6"; end
    else if (up != 0) begin e_mask = 4'b0001; e_pkt[UPC_L +: UP_W] = up - 1; e_req = "R2"; end
    else if (p[FLD_B]) begin e_mask = 4'b1110; e_req = "R5"; end
    else if (dn == 0) begin e_mask = 4'b0010; e_req = "R4"; end
    else if (s >= NC) begin e_drop = 1; e_req = "R7"; end
    else begin
      e_mask = 4'b0001 << (2 + s);
      e_pkt[LST_L +: 8] = {2'b00, p[LST_L+2 +: 6]};
      e_pkt[DNC_L +: DN_W] = dn - 1;
      e_req = "R3";
    end
  endtask

  task automatic set_in(int src, bit v, logic [PKT_W-1:0] d);
    case (src)
      0: begin par_in_v = v; par_in_d = d; end
      1: begin loc_in_v = v; loc_in_d = d; end
      default: begin chd_in_v[src-2] = v; chd_in_d[(src-2)*PKT_W +: PKT_W] = d; end
    endcase
  endtask

  function automatic logic [NP-1:0] rdy_vec();
    return {chd_in_r, loc_in_r, par_in_r};
  endfunction

  function automatic logic [NP-1:0] out_vec();
    return {chd_out_v, loc_out_v, par_out_v};
  endfunction

  function automatic logic [PKT_W-1:0] out_dat(int p);
    case (p)
      0: return par_out_d;
      1: return loc_out_d;
      default: return chd_out_d[(p-2)*PKT_W +: PKT_W];
    endcase
  endfunction

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(int src, logic [PKT_W-1:0] p);
    logic [NP-1:0] r;
    set_in(src, 1, p);
    #1;
    r = rdy_vec();
    while (!r[src]) begin @(negedge clk); #1; r = rdy_vec(); end
    @(posedge clk); @(negedge clk);
    set_in(src, 0, '0);
  endtask

  task automatic check_pkt(int src, logic [PKT_W-1:0] p);
    expect_of(p);
    send(src, p);
    chk(out_vec() == e_mask, e_req, "R10 output mask", 32'(out_vec()), 32'(e_mask));
    for (int q = 0; q < NP; q++)
      if (e_mask[q] && out_vec()[q])
        chk(out_dat(q) == e_pkt, e_req, "forwarded header", out_dat(q), e_pkt);
    chk(err == e_drop, e_req, "error pulse", 32'(err), 32'(e_drop));
    @(negedge clk);
    chk(out_vec() == 0 && err == 0, e_req, "idle after", {out_vec(), err}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] rv;
    logic [3:0] seen;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(out_vec() == 0 && err == 0, "R1", "in reset", {out_vec(), err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_vec() == 0 && err == 0, "R1", "after reset", {out_vec(), err}, 0);

    // directed corners
    check_pkt(2, mk(0, 2, 1, 8'h01, 16'h1111));   // R2 climb
    check_pkt(3, mk(0, 1, 0, 8'h00, 16'h1212));   // R2 last climb
    check_pkt(0, mk(0, 0, 3, 8'b00_01_00_01, 16'h2222)); // R3 child 1
    check_pkt(1, mk(0, 0, 4, 8'b01_00_01_00, 16'h2323)); // R3 full list child 0
    check_pkt(0, mk(0, 0, 0, 8'h00, 16'h3333));   // R4 local
    check_pkt(2, mk(1, 0, 2, 8'h05, 16'h4444));   // R5 flood at turning node
    check_pkt(3, mk(1, 1, 0, 8'h00, 16'h5555));   // R6 flood while climbing
    check_pkt(0, mk(0, 0, 1, 8'h03, 16'h6666));   // R7 selector out of range
    check_pkt(1, mk(0, 0, 2, 8'h02, 16'h6767));   // R7 selector 2

    // R8: flooded copies under partial backpressure
    chd_out_r = '0;
    send(0, mk(1, 0, 0, 8'h00, 16'h7777));
    chk(out_vec() == 4'b1110, "R8", "flood copies offered", 32'(out_vec()), 32'hE);
    @(negedge clk);
    chk(out_vec() == 4'b1100, "R8", "local taken, children held", 32'(out_vec()), 32'hC);
    chk(chd_out_d[PKT_W-1:0] == mk(1, 0, 0, 8'h00, 16'h7777), "R8", "held data", chd_out_d[31:0], 0);
    par_in_v = 1; par_in_d = mk(0, 0, 0, 8'h00, 16'h7878);
    #1;
    chk(rdy_vec() == 0, "R9", "no accept while held", 32'(rdy_vec()), 0);
    chd_out_r = 2'b01;
    @(negedge clk);
    chk(out_vec() == 4'b1000, "R8", "child0 taken", 32'(out_vec()), 32'h8);
    chd_out_r = 2'b11;
    @(negedge clk);
    chk(out_vec() == 0, "R8", "all taken, released", 32'(out_vec()), 0);
    #1;
    chk(rdy_vec() == 4'b0001, "R9", "parent accepted after release", 32'(rdy_vec()), 1);
    @(posedge clk); @(negedge clk);
    par_in_v = 0;
    chk(loc_out_v && loc_out_d[15:0] == 16'h7878, "R4", "queued local delivery", loc_out_d[15:0], 16'h7878);
    @(negedge clk);

    // R9: four contending inputs
    for (int s = 0; s < NP; s++) set_in(s, 1, mk(0, 0, 0, 8'h00, 16'hA0 + 16'(s)));
    seen = '0;
    for (int cyc = 0; cyc < 12; cyc++) begin
      #1;
      rv = rdy_vec();
      chk($countones(rv) <= 1, "R9", "single ready", 32'(rv), 0);
      @(posedge clk); @(negedge clk);
      for (int s = 0; s < NP; s++) if (rv[s]) set_in(s, 0, '0);
      if (loc_out_v) seen[loc_out_d[1:0]] = 1'b1;
    end
    chk(seen == 4'hF, "R9", "every input served", 32'(seen), 32'hF);

    // random mix
    for (int n = 0; n < 400; n++) begin
      bit fl;
      int up, dn, src;
      fl  = ($urandom % 4) == 0;
      up  = ($urandom % 3 == 0) ? int'($urandom % 3) + 1 : 0;
      dn  = int'($urandom % (MAXD + 1));
      src = int'($urandom % NP);
      check_pkt(src, mk(fl, up, dn, 8'($urandom), 16'($urandom)));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule